// File: doc/BRIEF.md
# APB Interrupt Source Combiner

This block sits on an APB slave port and merges a parameterised set of level-sensitive interrupt lines into one request for a parent interrupt controller. The number of lines, `NSRC`, is fixed when the block is built and may be anywhere from 2 to 64. Each line has an enable bit and a mask bit. A line counts as pending when it is high, enabled and not masked. The single output is raised while any line is pending.

Software reads two pending words to find out which lines need service. It then clears the cause at the peripheral that drives the line, and that drops the pending bit. Enable and mask bits exist only for lines that are built. Bits for absent lines always read zero. Software can therefore find `NSRC` by writing all ones to the enable words and reading them back.

Each line passes through a two-stage synchronizer before it reaches the pending logic, because the lines may be asynchronous to `pclk`.

Top module: `apb_irq_gather`

## Requirements
- R1: After reset, every enable bit and every mask bit is 0, `irq_out` is 0, and all four register words read 0.
- R2: Enable words: offset 0x00 holds lines 0 to 31 in bits 0 to 31, and offset 0x04 holds lines 32 to 63 in bits 0 to 31. Both are read/write for lines below `NSRC`. Bits for lines at or above `NSRC` read 0 and ignore writes, so with `NSRC`=40, writing 0xFFFFFFFF to 0x04 reads back 0x000000FF.
- R3: Mask words: offset 0x08 holds lines 0 to 31 and offset 0x0C holds lines 32 to 63, with the same bit layout and the same rule for absent lines as R2. A mask bit of 1 blocks its line and a mask bit of 0 passes it.
- R4: Pending words: offset 0x30 holds lines 0 to 31 and offset 0x34 holds lines 32 to 63, with the same bit layout as R2. Pending bit n equals synchronized line n AND enable n AND NOT mask n. These words are read-only, and writes to them have no effect.
- R5: `irq_out` is a registered OR of all pending bits. It rises three `pclk` edges after a line rises (two synchronizer stages plus the output stage). It changes one edge after an enable or mask write lands.
- R6: Lines are level-sensitive. `irq_out` stays high for as long as an enabled, unmasked line is held high. It falls three edges after that line is released.
- R7: Reads of any other offset return 0. Writes to any other offset change no register.
- R8: `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer ready, always 1 |
| pslverr | output | 1 | Error response, always 0 |
| src_in | input | NSRC | Level interrupt lines |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A mask write and the arrival of a synchronized line edge can fall on the same `pclk` edge. The bench raises a line on the negedge where a mask-setting write enters its setup phase. The line then leaves the synchronizer on the same edge where the write lands. Correct handling means `irq_out` never pulses. The bench samples it on each of the following cycles, and it also checks the one-edge lag after a plain mask write and the three-edge lag after a bare line change.

// File: rtl/apb_irq_gather.sv
module apb_irq_gather #(
  parameter int NSRC = 40,
  parameter int AW   = 8
) (
  input  logic            pclk,
  input  logic            presetn,
  input  logic            psel,
  input  logic            penable,
  input  logic            pwrite,
  input  logic [AW-1:0]   paddr,
  input  logic [31:0]     pwdata,
  output logic [31:0]     prdata,
  output logic            pready,
  output logic            pslverr,
  input  logic [NSRC-1:0] src_in,
  output logic            irq_out
);

  localparam logic [AW-1:0] A_EN_LO  = AW'(8'h00);
  localparam logic [AW-1:0] A_EN_HI  = AW'(8'h04);
  localparam logic [AW-1:0] A_MSK_LO = AW'(8'h08);
  localparam logic [AW-1:0] A_MSK_HI = AW'(8'h0C);
  localparam logic [AW-1:0] A_FS_LO  = AW'(8'h30);
  localparam logic [AW-1:0] A_FS_HI  = AW'(8'h34);

  logic            wr, rd;
  logic [NSRC-1:0] sync1, sync2;
  logic [63:0]     en_q, msk_q, fs;
  logic            irq_q;

  assign wr      = psel & penable & pwrite;
  assign rd      = psel & ~pwrite;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= src_in;
      sync2 <= sync1;
    end

  for (genvar i = 0; i < 64; i++) begin : g_bit
    if (i < NSRC) begin : g_on
      logic we_en, we_msk;
      if (i < 32) begin : g_lo
        assign we_en  = wr && paddr == A_EN_LO;
        assign we_msk = wr && paddr == A_MSK_LO;
      end else begin : g_hi
        assign we_en  = wr && paddr == A_EN_HI;
        assign we_msk = wr && paddr == A_MSK_HI;
      end
      always_ff @(posedge pclk or negedge presetn)
        if (!presetn) begin
          en_q[i]  <= 1'b0;
          msk_q[i] <= 1'b0;
        end else begin
          if (we_en)  en_q[i]  <= pwdata[i % 32];
          if (we_msk) msk_q[i] <= pwdata[i % 32];
        end
    end else begin : g_off
      assign en_q[i]  = 1'b0;
      assign msk_q[i] = 1'b0;
    end
  end

  assign fs = 64'(sync2) & en_q & ~msk_q;

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn) irq_q <= 1'b0;
    else          irq_q <= |fs;

  assign irq_out = irq_q;

  always_comb begin
    prdata = '0;
    if (rd)
      case (paddr)
        A_EN_LO:  prdata = en_q[31:0];
        A_EN_HI:  prdata = en_q[63:32];
        A_MSK_LO: prdata = msk_q[31:0];
        A_MSK_HI: prdata = msk_q[63:32];
        A_FS_LO:  prdata = fs[31:0];
        A_FS_HI:  prdata = fs[63:32];
        default:  prdata = '0;
      endcase
  end

endmodule

// File: rtl/apb_irq_gather_chk.sv
module apb_irq_gather_chk #(
  parameter int NSRC = 40,
  parameter int AW   = 8
) (
  input logic          pclk,
  input logic          presetn,
  input logic          psel,
  input logic          pwrite,
  input logic [AW-1:0] paddr,
  input logic [31:0]   prdata,
  input logic          pready,
  input logic          pslverr,
  input logic          irq_out,
  input logic [63:0]   fs,
  input logic [63:0]   msk
);

  logic mapped;
  assign mapped = paddr == AW'(8'h00) || paddr == AW'(8'h04) || paddr == AW'(8'h08) ||
                  paddr == AW'(8'h0C) || paddr == AW'(8'h30) || paddr == AW'(8'h34);

  a_r8_always_ready: assert property (@(posedge pclk) disable iff (!presetn)
    pready && !pslverr);

  a_r5_irq_registered: assert property (@(posedge pclk) disable iff (!presetn)
    1'b1 |=> irq_out == $past(|fs));

  a_r3_full_mask_quiet: assert property (@(posedge pclk) disable iff (!presetn)
    (&msk[NSRC-1:0]) |=> !irq_out);

  a_r7_unmapped_read_zero: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && !mapped) |-> prdata == 32'd0);

endmodule

bind apb_irq_gather apb_irq_gather_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .pwrite(pwrite), .paddr(paddr),
  .prdata(prdata), .pready(pready), .pslverr(pslverr), .irq_out(irq_out),
  .fs(fs), .msk(msk_q)
);

// File: tb/sim_apb_irq_gather.sv
module sim_apb_irq_gather;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 40;
  localparam int AW = 8;

  logic pclk = 0, presetn = 0, psel = 0, penable = 0, pwrite = 0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, pslverr, irq_out;
  logic [NSRC-1:0] src_in = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  apb_irq_gather #(.NSRC(NSRC), .AW(AW)) u0 (.*);

  always #(CLK_PERIOD/2) pclk = ~pclk;

  // src, enable, mask, expected irq
  localparam logic [120:0] VEC [0:7] = '{
    {40'h00_0000_0001, 40'h00_0000_0001, 40'h00_0000_0000, 1'b1},
    {40'h00_0000_0001, 40'h00_0000_0001, 40'h00_0000_0001, 1'b0},
    {40'h80_0000_0000, 40'h80_0000_0000, 40'h00_0000_0000, 1'b1},
    {40'h80_0000_0000, 40'h40_0000_0000, 40'h00_0000_0000, 1'b0},
    {40'hFF_FFFF_FFFF, 40'hFF_FFFF_FFFF, 40'hFF_FFFF_FFFF, 1'b0},
    {40'hAA_AAAA_AAAA, 40'h55_5555_5555, 40'h00_0000_0000, 1'b0},
    {40'h01_0000_0020, 40'h01_0000_0000, 40'h00_0000_0000, 1'b1},
    {40'h00_0000_0000, 40'hFF_FFFF_FFFF, 40'h00_0000_0000, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [AW-1:0] a, input logic [31:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [AW-1:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge pclk); penable = 1; #1;
    d = prdata;
    check(pready && !pslverr, "R8", {62'd0, pready, pslverr}, 64'd2);
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    logic [31:0] r, rh;
    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);

    // R1 reset state
    check(irq_out == 0, "R1", {63'd0, irq_out}, 64'd0);
    apb_read(8'h00, r); check(r == 0, "R1", {32'd0, r}, 64'd0);
    apb_read(8'h04, r); check(r == 0, "R1", {32'd0, r}, 64'd0);
    apb_read(8'h08, r); check(r == 0, "R1", {32'd0, r}, 64'd0);
    apb_read(8'h0C, r); check(r == 0, "R1", {32'd0, r}, 64'd0);

    // R2/R3 count discovery
    apb_write(8'h00, 32'hFFFF_FFFF); apb_write(8'h04, 32'hFFFF_FFFF);
    apb_read(8'h00, r); check(r == 32'hFFFF_FFFF, "R2", {32'd0, r}, 64'hFFFF_FFFF);
    apb_read(8'h04, r); check(r == 32'h0000_00FF, "R2", {32'd0, r}, 64'hFF);
    apb_write(8'h0C, 32'hFFFF_FFFF);
    apb_read(8'h0C, r); check(r == 32'h0000_00FF, "R3", {32'd0, r}, 64'hFF);
    apb_write(8'h0C, 32'h0);

    // R7 unmapped offsets
    apb_write(8'h10, 32'h1234_5678);
    apb_read(8'h10, r); check(r == 0, "R7", {32'd0, r}, 64'd0);
    apb_read(8'h08, r); check(r == 0, "R7", {32'd0, r}, 64'd0);
    apb_read(8'h00, r); check(r == 32'hFFFF_FFFF, "R7", {32'd0, r}, 64'hFFFF_FFFF);

    // R4 status read-only
    apb_write(8'h00, 32'h0); apb_write(8'h04, 32'h0);
    apb_write(8'h30, 32'hFFFF_FFFF); apb_write(8'h34, 32'hFFFF_FFFF);
    apb_read(8'h30, r); check(r == 0, "R4", {32'd0, r}, 64'd0);
    apb_read(8'h34, r); check(r == 0, "R4", {32'd0, r}, 64'd0);
    check(irq_out == 0, "R4", {63'd0, irq_out}, 64'd0);

    // Vector table: R3 R4 R5
    for (int k = 0; k < 8; k++) begin
      logic [39:0] vs, ve, vm, fexp;
      logic vi;
      {vs, ve, vm, vi} = VEC[k];
      apb_write(8'h00, ve[31:0]); apb_write(8'h04, {24'd0, ve[39:32]});
      apb_write(8'h08, vm[31:0]); apb_write(8'h0C, {24'd0, vm[39:32]});
      src_in = vs;
      repeat (4) @(negedge pclk);
      fexp = vs & ve & ~vm;
      check(irq_out == vi, "R5", {63'd0, irq_out}, {63'd0, vi});
      apb_read(8'h30, r); check(r == fexp[31:0], "R4", {32'd0, r}, {32'd0, fexp[31:0]});
      apb_read(8'h34, rh); check(rh == {24'd0, fexp[39:32]}, "R4", {32'd0, rh}, {56'd0, fexp[39:32]});
    end

    // R5 source latency, R6 level hold and release
    src_in = '0;
    apb_write(8'h00, 32'h1); apb_write(8'h04, 32'h0);
    apb_write(8'h08, 32'h0); apb_write(8'h0C, 32'h0);
    repeat (4) @(negedge pclk);
    src_in[0] = 1;
    repeat (2) @(negedge pclk);
    check(irq_out == 0, "R5", {63'd0, irq_out}, 64'd0);
    @(negedge pclk);
    check(irq_out == 1, "R5", {63'd0, irq_out}, 64'd1);
    repeat (5) @(negedge pclk);
    check(irq_out == 1, "R6", {63'd0, irq_out}, 64'd1);
    src_in[0] = 0;
    repeat (2) @(negedge pclk);
    check(irq_out == 1, "R6", {63'd0, irq_out}, 64'd1);
    @(negedge pclk);
    check(irq_out == 0, "R6", {63'd0, irq_out}, 64'd0);

    // R5 register-change latency
    src_in[0] = 1;
    repeat (4) @(negedge pclk);
    check(irq_out == 1, "R5", {63'd0, irq_out}, 64'd1);
    apb_write(8'h08, 32'h1);
    check(irq_out == 1, "R5", {63'd0, irq_out}, 64'd1);
    @(negedge pclk);
    check(irq_out == 0, "R3", {63'd0, irq_out}, 64'd0);

    // Same-edge collision: mask write lands as synchronized line rises
    src_in = '0;
    apb_write(8'h08, 32'h0); apb_write(8'h00, 32'h2);
    repeat (4) @(negedge pclk);
    src_in[1] = 1;
    apb_write(8'h08, 32'h2);
    for (int c = 0; c < 4; c++) begin
      check(irq_out == 0, "R3", {63'd0, irq_out}, 64'd0);
      @(negedge pclk);
    end
    apb_read(8'h30, r); check(r == 0, "R4", {32'd0, r}, 64'd0);

    // R8 outside transfers
    check(pready && !pslverr, "R8", {62'd0, pready, pslverr}, 64'd2);

    finish_run();
  end
endmodule